// File: doc/BRIEF.md
# Serial Debug-Bus Identification Responder

This block is the chip-side end of a serial debug bus. A host selects a debug path by raising the address-mode line and clocking in a 16-bit path address, one bit per rising edge of the shift clock. When address mode drops, the block decodes the captured address. If the location fields equal the chip's own strap inputs and the path field names the identification path, the block presents a 16-bit identity word on the serial output, most significant bit first. The host then reads the remaining bits with further rising edges of the shift clock.

The debug lines are not used as clocks. They are sampled with the system clock through one register stage. Edges of the shift clock and of address mode are found by comparing each sampled value with the value held one cycle earlier. The identity word is a fixed 4-bit prefix followed by a type code and a version code, and both codes are parameters.

Top module: `dbg_id_responder`

## Requirements
- R1: While address mode is high, each rising edge of the shift clock shifts the serial input into the address register at the low end. After 16 edges, the first bit sent is bit 15.
- R2: The address is decoded from bit 15 down in this order: board [15:12], hybrid [11:8], interface [7:5], chip [4:3], path [2:0]. Board, hybrid, interface and chip must each equal the matching strap input.
- R3: Only path value 1 selects the identification path. Any other path value gives a non-matching address.
- R4: The identity word is, from bit 15 down: the prefix 0101, then the 6-bit type, then the 6-bit version.
- R5: Once address mode has fallen on a matching address, bit 15 of the identity word is on the serial output before any shift-clock edge. Each rising edge while address mode is low moves to the next lower bit, so bit 0 appears after 15 edges.
- R6: If the address does not match, the serial output stays 0 for the whole readout.
- R7: After the rising edge that follows bit 0, the serial output stays 0 until a new address phase is entered.
- R8: Reset, and the debug reset input, clear the address register and the readout pointer. After either one, the serial output is 0. An address phase with no shift edges then decodes address 0, which does not match.
- R9: While address mode is high, the serial output is 0.
- R10: Shift-clock edges while address mode is low do not change the stored address. A new address phase with no shift edges reads the previous identity again from bit 15.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, synchronous |
| dbg_rst | input | 1 | Debug reset, synchronous, active high |
| addr_mode | input | 1 | High during address entry |
| shift_ck | input | 1 | Debug shift clock, sampled |
| serial_in | input | 1 | Address bit from the host |
| board_id | input | 4 | Board strap |
| hybrid_id | input | 4 | Hybrid strap |
| iface_id | input | 3 | Interface strap |
| chip_id | input | 2 | Chip strap |
| serial_out | output | 1 | Identity bit to the host |

## Verification
The hardest case to reach is the sequence around the end of a readout: the edge after bit 0, a repeated address phase with no shift edges, and a debug reset between two phases. Each of these needs a full address entry and a long run of shift-clock toggles first. The bench drives each shift-clock level for several system clocks and samples between edges. It runs a table of matching and near-miss addresses through a full readout and then replays these end cases directly.

// File: rtl/dbg_pkg.sv
package dbg_pkg;
  localparam int BRD_W  = 4;
  localparam int HYB_W  = 4;
  localparam int IFC_W  = 3;
  localparam int CHP_W  = 2;
  localparam int PTH_W  = 3;
  localparam int ADDR_W = BRD_W + HYB_W + IFC_W + CHP_W + PTH_W;
  localparam logic [PTH_W-1:0] PATH_IDENT = 3'd1;
  localparam int TYPE_W = 6;
  localparam int VER_W  = 6;
  localparam logic [3:0] ID_PFX = 4'b0101;
  localparam int ID_W   = 4 + TYPE_W + VER_W;
  localparam int PTR_W  = $clog2(ID_W);

  typedef struct packed {
    logic [BRD_W-1:0] brd;
    logic [HYB_W-1:0] hyb;
    logic [IFC_W-1:0] ifc;
    logic [CHP_W-1:0] chp;
    logic [PTH_W-1:0] pth;
  } dbg_addr_t;
endpackage

// File: rtl/dbg_edge_sync.sv
module dbg_edge_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic ck_in,
  input  logic am_in,
  input  logic si_in,
  output logic ck_rise,
  output logic am_fall,
  output logic am_lvl,
  output logic si_lvl
);
  logic s_ck, s_am, s_si, p_ck, p_am;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s_ck <= 1'b0; s_am <= 1'b0; s_si <= 1'b0;
      p_ck <= 1'b0; p_am <= 1'b0;
    end else begin
      s_ck <= ck_in; s_am <= am_in; s_si <= si_in;
      p_ck <= s_ck;  p_am <= s_am;
    end
  end

  assign ck_rise = s_ck & ~p_ck;
  assign am_fall = p_am & ~s_am;
  assign am_lvl  = s_am;
  assign si_lvl  = s_si;

  // R5: a falling edge of address mode is seen for exactly one cycle
  p_fall_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    am_fall |=> !am_fall);
endmodule

// File: rtl/dbg_addr_shift.sv
module dbg_addr_shift
  import dbg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             shift_en,
  input  logic             si,
  input  logic [BRD_W-1:0] brd_strap,
  input  logic [HYB_W-1:0] hyb_strap,
  input  logic [IFC_W-1:0] ifc_strap,
  input  logic [CHP_W-1:0] chp_strap,
  output logic             hit
);
  dbg_addr_t addr_q;

  always_ff @(posedge clk) begin
    if (!rst_n || clr)
      addr_q <= '0;
    else if (shift_en)
      addr_q <= {addr_q[ADDR_W-2:0], si};
  end

  assign hit = (addr_q.brd == brd_strap) && (addr_q.hyb == hyb_strap) &&
               (addr_q.ifc == ifc_strap) && (addr_q.chp == chp_strap) &&
               (addr_q.pth == PATH_IDENT);

  p_shift_lsb_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_en && !clr) |=> addr_q[0] == $past(si));
  p_addr_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!shift_en && !clr) |=> $stable(addr_q));
  p_addr_clr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> addr_q == '0);
endmodule

// File: rtl/dbg_id_serializer.sv
module dbg_id_serializer
  import dbg_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic            hold_off,
  input  logic            start,
  input  logic            advance,
  input  logic            hit,
  input  logic [ID_W-1:0] id_word,
  output logic            serial_out
);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(ID_W - 1);

  logic             active, sel;
  logic [PTR_W-1:0] idx;

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      active <= 1'b0; sel <= 1'b0; idx <= '0;
    end else if (hold_off) begin
      active <= 1'b0;
    end else if (start) begin
      active <= 1'b1; sel <= hit; idx <= '0;
    end else if (advance && active) begin
      if (idx == LAST) active <= 1'b0;
      else             idx <= idx + 1'b1;
    end
  end

  assign serial_out = active & sel & id_word[LAST - idx];

  p_ptr_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && active && idx != LAST && !clr && !hold_off && !start)
      |=> idx == $past(idx) + 1'b1);
  p_end_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && active && idx == LAST && !clr && !hold_off && !start)
      |=> !serial_out);
  p_clr_ptr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (idx == '0) && !serial_out);
endmodule

// File: rtl/dbg_id_responder.sv
module dbg_id_responder
  import dbg_pkg::*;
#(
  parameter logic [TYPE_W-1:0] ID_TYPE = 6'd9,
  parameter logic [VER_W-1:0]  ID_VER  = 6'd1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dbg_rst,
  input  logic             addr_mode,
  input  logic             shift_ck,
  input  logic             serial_in,
  input  logic [BRD_W-1:0] board_id,
  input  logic [HYB_W-1:0] hybrid_id,
  input  logic [IFC_W-1:0] iface_id,
  input  logic [CHP_W-1:0] chip_id,
  output logic             serial_out
);
  localparam logic [ID_W-1:0] ID_WORD = {ID_PFX, ID_TYPE, ID_VER};

  logic ck_rise, am_fall, am_lvl, si_lvl, hit;

  dbg_edge_sync u_sync (
    .clk(clk), .rst_n(rst_n), .ck_in(shift_ck), .am_in(addr_mode),
    .si_in(serial_in), .ck_rise(ck_rise), .am_fall(am_fall),
    .am_lvl(am_lvl), .si_lvl(si_lvl)
  );

  dbg_addr_shift u_addr (
    .clk(clk), .rst_n(rst_n), .clr(dbg_rst), .shift_en(am_lvl & ck_rise),
    .si(si_lvl), .brd_strap(board_id), .hyb_strap(hybrid_id),
    .ifc_strap(iface_id), .chp_strap(chip_id), .hit(hit)
  );

  dbg_id_serializer u_ser (
    .clk(clk), .rst_n(rst_n), .clr(dbg_rst), .hold_off(am_lvl),
    .start(am_fall), .advance(ck_rise & ~am_lvl), .hit(hit),
    .id_word(ID_WORD), .serial_out(serial_out)
  );

  p_quiet_addr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    am_lvl |=> !serial_out);
  p_miss_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (am_fall && !hit && !dbg_rst) |=> !serial_out);
  p_first_bit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (am_fall && hit && !dbg_rst) |=> serial_out == ID_WORD[ID_W-1]);
endmodule

// File: tb/tb_dbg_id_responder.sv
module tb_dbg_id_responder;
  localparam int CLK_P = 10;
  localparam logic [5:0] T_TYPE = 6'd9;
  localparam logic [5:0] T_VER  = 6'd1;
  localparam logic [15:0] ID = {4'b0101, T_TYPE, T_VER};
  localparam logic [15:0] GOOD = {4'd3, 4'd5, 3'd2, 2'd1, 3'd1};
  localparam int NV = 7;
  // address, expected match
  localparam logic [16:0] VEC [NV] = '{
    {GOOD, 1'b1},
    {4'd3, 4'd5, 3'd2, 2'd1, 3'd0, 1'b0},
    {4'd3, 4'd5, 3'd2, 2'd1, 3'd2, 1'b0},
    {4'd4, 4'd5, 3'd2, 2'd1, 3'd1, 1'b0},
    {4'd3, 4'd6, 3'd2, 2'd1, 3'd1, 1'b0},
    {4'd3, 4'd5, 3'd3, 2'd1, 3'd1, 1'b0},
    {4'd3, 4'd5, 3'd2, 2'd0, 3'd1, 1'b0}
  };

  logic clk = 0, rst_n = 0, dbg_rst = 0, am = 0, sck = 0, si = 0;
  logic so;
  int checks = 0, errors = 0;

  always #(CLK_P/2) clk = ~clk;

  dbg_id_responder #(.ID_TYPE(T_TYPE), .ID_VER(T_VER)) dut (
    .clk(clk), .rst_n(rst_n), .dbg_rst(dbg_rst), .addr_mode(am),
    .shift_ck(sck), .serial_in(si), .board_id(4'd3), .hybrid_id(4'd5),
    .iface_id(3'd2), .chip_id(2'd1), .serial_out(so)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  task automatic rise();
    sck = 1; settle(); sck = 0; settle();
  endtask

  task automatic send_addr(input logic [15:0] a, input int n);
    am = 1; settle();
    for (int i = 15; i >= 16 - n; i--) begin si = a[i]; rise(); end
    am = 0; settle();
  endtask

  task automatic read_word(output logic [15:0] w);
    w[15] = so;
    for (int i = 14; i >= 0; i--) begin rise(); w[i] = so; end
  endtask

  logic [15:0] w;

  initial begin
    repeat (3) @(negedge clk);
    chk("R8 reset", {15'd0, so}, 16'd0);
    rst_n = 1; settle();

    foreach (VEC[k]) begin
      send_addr(VEC[k][16:1], 16);
      chk("R5 first bit before edge", {15'd0, so}, {15'd0, VEC[k][0] ? ID[15] : 1'b0});
      read_word(w);
      chk(VEC[k][0] ? "R1 R2 R3 R4 R5 match word" : "R2 R3 R6 miss word",
          w, VEC[k][0] ? ID : 16'd0);
    end

    // R7: edge after bit 0 leaves output low
    send_addr(GOOD, 16);
    read_word(w);
    chk("R4 word", w, ID);
    rise();
    chk("R7 after last", {15'd0, so}, 16'd0);
    rise();
    chk("R7 still low", {15'd0, so}, 16'd0);

    // R10: address retained; new phase without shifts rereads
    send_addr(GOOD, 0);
    read_word(w);
    chk("R10 reread", w, ID);

    // R9: output low while in address mode
    send_addr(GOOD, 16);
    rise(); // now showing bit 14 = 1
    chk("R5 second bit", {15'd0, so}, {15'd0, ID[14]});
    am = 1; settle();
    chk("R9 addr mode quiet", {15'd0, so}, 16'd0);
    am = 0; settle();

    // R8: debug reset clears pointer and address
    send_addr(GOOD, 16);
    rise();
    dbg_rst = 1; @(negedge clk); dbg_rst = 0; settle();
    chk("R8 dbg reset output", {15'd0, so}, 16'd0);
    send_addr(GOOD, 0);
    read_word(w);
    chk("R8 address cleared", w, 16'd0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=hang expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule